// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host a four-register window through which it can reach a much larger internal space of 32-bit registers. The host loads a target address, and for a store also a data word. It then sets one command bit. The bridge issues exactly one request on an internal valid/ready register bus and sets a sticky acknowledge flag once that bus has answered. For a load, the returned word is held in a read-only data register.

The acknowledge flag and the returned word stay in place until the host writes a command value whose two request bits are zero. That write clears the command register on the next clock edge. From then on the bridge is ready for a fresh access.

The window is decoded on word offsets:

| Offset | Register |
| --- | --- |
| 0x0 | command |
| 0x4 | address |
| 0x8 | returned data, read-only |
| 0xC | store data |

In the command register, bit 0 requests a load, bit 1 requests a store, and bit 2 is the acknowledge flag.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the command, address, returned-data and store-data registers all read as zero, and `bus_valid` is low.
- R2: Window decode uses byte offsets 0x0 (command), 0x4 (address), 0x8 (returned data) and 0xC (store data). Host writes to 0x8 leave the returned-data register unchanged. The command register reads back with bit 0 = load pending, bit 1 = store pending, bit 2 = acknowledge, and all other bits zero.
- R3: The address register stores the written value with bits 1:0 forced to zero, and every bus request carries an address whose bits 1:0 are zero.
- R4: When the bridge is idle, writing a command with bit 0 set and bit 1 clear raises `bus_valid` on the next clock edge, with `bus_write` low and `bus_addr` equal to the address register.
- R5: When the bridge is idle, writing a command with bit 1 set and bit 0 clear raises `bus_valid` on the next clock edge, with `bus_write` high and `bus_wdata` equal to the store-data register.
- R6: A launched request holds `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` steady until `bus_ready` is seen. Each accepted command produces exactly one bus handshake.
- R7: The acknowledge bit becomes visible on the clock edge that samples `bus_valid` and `bus_ready` both high. On a load, the returned-data register takes `bus_rdata` on that same edge.
- R8: While a command is pending or acknowledged, the acknowledge bit and the returned data stay unchanged. Command writes with a request bit set are ignored in that state: no new bus request starts and the command register keeps its value.
- R9: A command write with bits 1:0 both zero clears the whole command register, acknowledge included, on the next clock edge. A new command written right after is accepted.
- R10: A command write with bits 0 and 1 both set starts no bus request and leaves the command register at zero.
- R11: A completed store leaves the returned-data register unchanged.
- R12: If the command is cleared while its bus request is still outstanding, the request still completes on the bus, but the acknowledge bit never sets and the returned data is discarded. Command writes made before that request completes are ignored.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe for the window |
| host_addr | input | 4 | Byte offset into the window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Window read data for the current `host_addr` |
| bus_valid | output | 1 | Internal request valid |
| bus_write | output | 1 | Internal request is a store |
| bus_addr | output | 32 | Internal request address, word aligned |
| bus_wdata | output | 32 | Internal store data |
| bus_ready | input | 1 | Internal bus accepts the request (and returns data) |
| bus_rdata | input | 32 | Internal load data, valid with `bus_ready` |

## Verification
The assertions take for granted that the internal bus eventually raises `bus_ready` for every request. They also assume `bus_ready` is only meaningful while `bus_valid` is high, and that the host writes the window one register per strobe with aligned offsets. The bench stays within these limits. It drives host writes and offsets only on falling edges, one register at a time. Its bus responder raises `bus_ready` only against a live request, after a chosen latency of zero to eight cycles, and drops it after each handshake.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int WIN_AW      = 4;
  localparam int CMD_RD_BIT  = 0;
  localparam int CMD_WR_BIT  = 1;
  localparam int CMD_ACK_BIT = 2;

  localparam logic [1:0] SEL_CMD   = 2'd0;
  localparam logic [1:0] SEL_ADDR  = 2'd1;
  localparam logic [1:0] SEL_RDATA = 2'd2;
  localparam logic [1:0] SEL_WDATA = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_DONE  = 2'd2,
    ST_DRAIN = 2'd3
  } ibr_state_e;
endpackage

// File: rtl/ibr_host_regs.sv
module ibr_host_regs
  import ibr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [WIN_AW-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  input  logic [2:0]        cmd_view,
  input  logic              rd_load,
  input  logic [DW-1:0]     rd_value,
  output logic              cmd_wr,
  output logic [1:0]        cmd_bits,
  output logic [AW-1:0]     addr_q,
  output logic [DW-1:0]     wdata_q
);
  logic [1:0]    sel;
  logic          word_ok;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] wdata_d;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rdata_d;
  logic          addr_en;
  logic          wdata_en;

  assign sel      = host_addr[WIN_AW-1:WIN_AW-2];
  assign word_ok  = (host_addr[1:0] == 2'b00);
  assign cmd_wr   = host_we && word_ok && (sel == SEL_CMD);
  assign cmd_bits = host_wdata[1:0];
  assign addr_en  = host_we && word_ok && (sel == SEL_ADDR);
  assign wdata_en = host_we && word_ok && (sel == SEL_WDATA);

  always_comb begin
    addr_d  = addr_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    if (addr_en)  addr_d  = {host_wdata[AW-1:2], 2'b00};
    if (wdata_en) wdata_d = host_wdata;
    if (rd_load)  rdata_d = rd_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (word_ok) begin
      case (sel)
        SEL_CMD:   host_rdata = DW'(cmd_view);
        SEL_ADDR:  host_rdata = DW'(addr_q);
        SEL_RDATA: host_rdata = rdata_q;
        default:   host_rdata = wdata_q;
      endcase
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_view[CMD_ACK_BIT] && !cmd_wr) |=> $stable(rdata_q)); // R8
  AST_ADDR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q[1:0] == 2'b00); // R3
endmodule

// File: rtl/ibr_cmd_fsm.sv
module ibr_cmd_fsm
  import ibr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [1:0] cmd_bits,
  input  logic       bus_done,
  output logic       launch,
  output logic       launch_wr,
  output logic       rd_load,
  output logic [2:0] cmd_view
);
  ibr_state_e state_q, state_d;
  logic rd_q, rd_d;
  logic wr_q, wr_d;
  logic cmd_clear;
  logic cmd_go;
  logic ack;

  assign cmd_clear = cmd_wr && (cmd_bits == 2'b00);
  assign cmd_go    = cmd_wr && (cmd_bits[0] ^ cmd_bits[1]);
  assign launch_wr = cmd_bits[CMD_WR_BIT];
  assign ack       = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    rd_d    = rd_q;
    wr_d    = wr_q;
    launch  = 1'b0;
    rd_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_go) begin
          state_d = ST_BUSY;
          rd_d    = cmd_bits[CMD_RD_BIT];
          wr_d    = cmd_bits[CMD_WR_BIT];
          launch  = 1'b1;
        end
      end
      ST_BUSY: begin
        if (cmd_clear) begin
          rd_d    = 1'b0;
          wr_d    = 1'b0;
          state_d = bus_done ? ST_IDLE : ST_DRAIN;
        end else if (bus_done) begin
          state_d = ST_DONE;
          rd_load = rd_q;
        end
      end
      ST_DONE: begin
        if (cmd_clear) begin
          rd_d    = 1'b0;
          wr_d    = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: begin
        if (bus_done) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      rd_q    <= rd_d;
      wr_q    <= wr_d;
    end
  end

  assign cmd_view = {ack, wr_q, rd_q};

  AST_ACK_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(bus_done)); // R7
  AST_ACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !cmd_clear) |=> ack); // R8
  AST_CLEAR_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clear |=> (cmd_view == 3'b000)); // R9
  AST_BOTH_BITS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (cmd_bits == 2'b11) && (state_q == ST_IDLE)) |=> (cmd_view == 3'b000)); // R10
endmodule

// File: rtl/ibr_bus_master.sv
module ibr_bus_master #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          launch_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          bus_done,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready
);
  logic valid_d;

  assign bus_done = bus_valid && bus_ready;

  always_comb begin
    valid_d = bus_valid;
    if (launch)        valid_d = 1'b1;
    else if (bus_done) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
    end else begin
      bus_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (launch) begin
      bus_write <= launch_wr;
      bus_addr  <= req_addr;
      bus_wdata <= req_wdata;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)
      && $stable(bus_write) && $stable(bus_wdata))); // R6
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !bus_valid); // R6
  AST_BUS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_addr[1:0] == 2'b00)); // R3
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ibr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [WIN_AW-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_wdata,
  input  logic              bus_ready,
  input  logic [DW-1:0]     bus_rdata
);
  logic          cmd_wr;
  logic [1:0]    cmd_bits;
  logic [2:0]    cmd_view;
  logic          launch;
  logic          launch_wr;
  logic          rd_load;
  logic          bus_done;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  ibr_host_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .cmd_view   (cmd_view),
    .rd_load    (rd_load),
    .rd_value   (bus_rdata),
    .cmd_wr     (cmd_wr),
    .cmd_bits   (cmd_bits),
    .addr_q     (addr_q),
    .wdata_q    (wdata_q)
  );

  ibr_cmd_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_bits  (cmd_bits),
    .bus_done  (bus_done),
    .launch    (launch),
    .launch_wr (launch_wr),
    .rd_load   (rd_load),
    .cmd_view  (cmd_view)
  );

  ibr_bus_master #(.AW(AW), .DW(DW)) u_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .launch_wr (launch_wr),
    .req_addr  (addr_q),
    .req_wdata (wdata_q),
    .bus_done  (bus_done),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready)
  );

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> ($past(cmd_view) == 3'b000)); // R8
endmodule

// File: tb/ind_reg_bridge_bench.sv
module ind_reg_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        bus_valid, bus_write;
  logic [31:0] bus_addr, bus_wdata;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  int lat = 0;
  int cnt = 0;
  int cyc = 0;
  int n_hs = 0;

  typedef struct {bit wr; logic [31:0] a; logic [31:0] d;} xact_t;
  xact_t exp_q[$];

  always #2 clk = ~clk;

  ind_reg_bridge u_ind_reg_bridge (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] rmodel(logic [31:0] a);
    return (a * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [3:0] ofs, logic [31:0] val);
    @(negedge clk);
    host_we = 1'b1; host_addr = ofs; host_wdata = val;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(logic [3:0] ofs, output logic [31:0] val);
    host_addr = ofs;
    #1;
    val = host_rdata;
  endtask

  task automatic push_exp(bit wr, logic [31:0] a, logic [31:0] d);
    xact_t x;
    x.wr = wr; x.a = a; x.d = d;
    exp_q.push_back(x);
  endtask

  task automatic wait_ack(output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      hread(4'h0, v);
      if (v[2]) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // Bus responder and scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      cnt <= 0;
    end else if (bus_ready) begin
      bus_ready <= 1'b0;
      cnt <= 0;
    end else if (bus_valid) begin
      if (cnt >= lat) begin
        bus_ready <= 1'b1;
        bus_rdata <= rmodel(bus_addr);
        n_hs++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected bus access", bus_addr, 32'h0);
        end else begin
          xact_t x;
          x = exp_q.pop_front();
          chk(bus_write == x.wr, "R4/R5 bus_write", 32'(bus_write), 32'(x.wr));
          chk(bus_addr == x.a, "R3 bus_addr", bus_addr, x.a);
          if (x.wr) chk(bus_wdata == x.d, "R5 bus_wdata", bus_wdata, x.d);
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL R6 watchdog actual=%0d cycles expected<50000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] keep;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    hread(4'h0, v); chk(v == 0, "R1 cmd reset", v, 0);
    hread(4'h4, v); chk(v == 0, "R1 addr reset", v, 0);
    hread(4'h8, v); chk(v == 0, "R1 rdata reset", v, 0);
    hread(4'hC, v); chk(v == 0, "R1 wdata reset", v, 0);
    chk(bus_valid == 0, "R1 bus_valid reset", 32'(bus_valid), 0);

    // R3 alignment of address register
    hwrite(4'h4, 32'h1234_5677);
    hread(4'h4, v); chk(v == 32'h1234_5674, "R3 addr aligned", v, 32'h1234_5674);

    // R4/R7 load with zero latency, exact cycle timing
    lat = 0;
    push_exp(1'b0, 32'h1234_5674, 0);
    hwrite(4'h0, 32'h1);
    chk(bus_valid == 1, "R4 valid after cmd", 32'(bus_valid), 1);
    chk(bus_write == 0, "R4 load direction", 32'(bus_write), 0);
    hread(4'h0, v); chk(v == 32'h1, "R7 no ack before ready", v, 32'h1);
    @(negedge clk);
    hread(4'h0, v); chk(v == 32'h5, "R7 ack after ready", v, 32'h5);
    chk(bus_valid == 0, "R6 valid dropped", 32'(bus_valid), 0);
    hread(4'h8, v); chk(v == rmodel(32'h1234_5674), "R7 rdata", v, rmodel(32'h1234_5674));
    keep = v;

    // R8 command ignored while acknowledged
    hwrite(4'h0, 32'h2);
    chk(bus_valid == 0, "R8 no new access", 32'(bus_valid), 0);
    hread(4'h0, v); chk(v == 32'h5, "R8 cmd held", v, 32'h5);
    repeat (3) @(negedge clk);
    hread(4'h0, v); chk(v == 32'h5, "R8 ack sticky", v, 32'h5);
    hread(4'h8, v); chk(v == keep, "R8 rdata stable", v, keep);

    // R2 returned-data register is read-only
    hwrite(4'h8, 32'hFFFF_0000);
    hread(4'h8, v); chk(v == keep, "R2 rdata read-only", v, keep);

    // R9 clear and immediate reuse; R5 store with latency
    hwrite(4'h0, 32'h0);
    hread(4'h0, v); chk(v == 0, "R9 cleared next edge", v, 0);
    lat = 3;
    hwrite(4'hC, 32'hDEAD_BEEF);
    hwrite(4'h4, 32'h0000_0040);
    hread(4'hC, v); chk(v == 32'hDEAD_BEEF, "R2 wdata readback", v, 32'hDEAD_BEEF);
    push_exp(1'b1, 32'h40, 32'hDEAD_BEEF);
    hwrite(4'h0, 32'h2);
    chk(bus_valid == 1 && bus_write == 1, "R5 store launched",
        {bus_valid, bus_write}, 2'b11);
    wait_ack(ok); chk(ok, "R5 store acknowledged", 32'(ok), 1);
    hread(4'h0, v); chk(v == 32'h6, "R2 cmd format store", v, 32'h6);
    hread(4'h8, v); chk(v == keep, "R11 rdata unchanged by store", v, keep);
    hwrite(4'h0, 32'h0);

    // R10 both request bits
    hwrite(4'h0, 32'h3);
    chk(bus_valid == 0, "R10 no access", 32'(bus_valid), 0);
    hread(4'h0, v); chk(v == 0, "R10 cmd zero", v, 0);
    repeat (4) @(negedge clk);
    chk(bus_valid == 0, "R10 still idle", 32'(bus_valid), 0);

    // R12 clear while request outstanding
    lat = 8;
    hwrite(4'h4, 32'h0000_0100);
    push_exp(1'b0, 32'h100, 0);
    hwrite(4'h0, 32'h1);
    @(negedge clk);
    hwrite(4'h0, 32'h0);
    hread(4'h0, v); chk(v == 0, "R12 cmd cleared", v, 0);
    chk(bus_valid == 1, "R12 request still out", 32'(bus_valid), 1);
    hwrite(4'h0, 32'h1);
    for (int i = 0; i < 40 && bus_valid; i++) @(negedge clk);
    @(negedge clk);
    hread(4'h0, v); chk(v == 0, "R12 no ack", v, 0);
    hread(4'h8, v); chk(v == keep, "R12 data discarded", v, keep);
    repeat (3) @(negedge clk);
    chk(bus_valid == 0, "R12 ignored cmd not launched", 32'(bus_valid), 0);

    // R4 another load after abort, latency 2
    lat = 2;
    hwrite(4'h4, 32'hCAFE_0008);
    push_exp(1'b0, 32'hCAFE_0008, 0);
    hwrite(4'h0, 32'h1);
    wait_ack(ok); chk(ok, "R4 load acknowledged", 32'(ok), 1);
    hread(4'h8, v); chk(v == rmodel(32'hCAFE_0008), "R7 rdata second load", v, rmodel(32'hCAFE_0008));
    hwrite(4'h0, 32'h0);
    repeat (4) @(negedge clk);

    chk(exp_q.size() == 0, "R6 all expected accesses seen", exp_q.size(), 0);
    chk(n_hs == 4, "R6 one handshake per command", n_hs, 4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule